// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block decides which of a set of interrupt request lines is handed to the processor, and when. Each source has a two-bit priority level that software can write. Level 0 is the most urgent and level 3 the least. When two sources share a level, the source with the smaller index wins. Requests are caught in sticky pending flags. A grant can happen only while the global enable is set. A grant clears the enable, clears the granted flag, and records the granted level on a four-entry in-service stack. An end-of-service strobe removes the top entry, so the level below it becomes the comparison level again.

A request may interrupt running service only when its level is strictly more urgent than the level on top of the stack. The one exception is the least urgent level, level 3. A single control bit decides whether a level-3 request may nest inside level-3 service or must wait. Setting the enable again inside a handler lets any waiting request through, as long as the nesting rule allows it.

A small state machine follows the stack occupancy. It has three states:
- ST_IDLE: nothing is in service.
- ST_ACTIVE: one to three entries are in service.
- ST_FULL: all four entries are used.

Its transitions are:
- grant-from-idle: ST_IDLE to ST_ACTIVE.
- grant-to-full: ST_ACTIVE to ST_FULL, taken on the grant that fills the last entry.
- last-return: ST_ACTIVE to ST_IDLE, taken on an end-of-service strobe at depth 1.
- unwind: ST_FULL to ST_ACTIVE, taken on any end-of-service strobe.
- ST_ACTIVE to ST_ACTIVE on every other grant or end-of-service strobe.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset the following all read zero: `ack_o`, `ie_o`, `pend_o`, `srv_depth_o` and `srv_lvl_o`. Every source level resets to 3, and the level-3 nesting inhibit resets to 0.
- R2: A request pulse on `req_i[s]` sets the pending flag `pend_o[s]`. The flag stays set until source s is granted. No grant happens while `ie_o` is 0.
- R3: With nothing in service and `ie_o`=1, the most urgent pending request is granted whatever its level. The most urgent request is the one with the smallest level value, and among equal levels the one with the smallest index. `ack_o` rises on the clock edge after the decision.
- R4: A grant behaves as follows:
  - `ack_o` is high for exactly one cycle.
  - `ack_idx_o` carries the source index.
  - `ie_o` clears.
  - The granted pending flag clears in the same edge, unless a new pulse for that source arrives in that cycle.
  - The granted level is pushed, so `srv_lvl_o` shows it and `srv_depth_o` rises by one.
- R5: During service, a request of level 0, 1 or 2 is granted only if its level value is strictly less than `srv_lvl_o`. Otherwise it stays pending.
- R6: The nesting inhibit is written through `ctl_we_i`/`ctl_nest_off_i`. During level-3 service, a level-3 request behaves as follows:
  - With the inhibit at 1, it stays pending even with `ie_o`=1.
  - With the inhibit at 0, it is granted and nests.
- R7: An `eos_i` pulse decrements `srv_depth_o` by one, and `srv_lvl_o` then shows the entry below (0 when empty). An `eos_i` pulse at depth 0 has no effect. No grant is made in a cycle with `eos_i` high.
- R8: At depth 4 no grant is made, even when a request would otherwise qualify.
- R9: `ie_set_i` sets `ie_o` and `ie_clr_i` clears it. A clear wins over a set in the same cycle, and a grant wins over both.
- R10: Among pending requests of the same level, the one with the lower source index is granted first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | NSRC | Request pulses, one per source |
| lvl_we_i | input | 1 | Write strobe for a source level |
| lvl_sel_i | input | SW | Source whose level is written |
| lvl_val_i | input | LW | New level value |
| ctl_we_i | input | 1 | Write strobe for the nesting inhibit |
| ctl_nest_off_i | input | 1 | 1 blocks level-3 nesting inside level-3 service |
| ie_set_i | input | 1 | Set the global enable |
| ie_clr_i | input | 1 | Clear the global enable |
| eos_i | input | 1 | End-of-service strobe (pops the stack) |
| ack_o | output | 1 | One-cycle grant pulse |
| ack_idx_o | output | SW | Index of the granted source |
| ie_o | output | 1 | Global enable state |
| pend_o | output | NSRC | Pending flags |
| srv_depth_o | output | DW | Number of levels in service |
| srv_lvl_o | output | LW | Level on top of the in-service stack (0 when empty) |

## Verification
The embedded properties check the following on every cycle:
- Every grant was made with the enable set.
- The acknowledge lasts one cycle and leaves the enable clear.
- Each grant during service either has a strictly more urgent level, or is a level-3-in-level-3 nest with the inhibit off.
- The stack never overflows and pops by exactly one.
- The state register agrees with the stack occupancy.

Only the bench scenarios can show the following:
- Which source wins a tie.
- That an inhibited or less urgent request really stays pending and is granted later, once the rules allow it.
- That a full stack holds off an eligible request.
- How the set/clear strobes are ordered.

// File: rtl/nic_pkg.sv
package nic_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_FULL   = 2'd2
    } nic_state_e;
endpackage

// File: rtl/nic_arbiter.sv
// Picks the most urgent pending source: lowest level value, then lowest index.
module nic_arbiter #(
    parameter int NSRC = 8,
    parameter int LW   = 2,
    parameter int SW   = 3
) (
    input  logic [NSRC-1:0]         pend_i,
    input  logic [NSRC-1:0][LW-1:0] lvl_i,
    output logic                    any_o,
    output logic [SW-1:0]           idx_o,
    output logic [LW-1:0]           lvl_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        lvl_o = '1;
        // Scan downward with <= so the smaller index wins a level tie (R10)
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend_i[i] && (!any_o || lvl_i[i] <= lvl_o)) begin
                any_o = 1'b1;
                idx_o = SW'(i);
                lvl_o = lvl_i[i];
            end
        end
    end
endmodule

// File: rtl/nic_nest_gate.sv
// Decides whether a candidate level may interrupt the level in service.
module nic_nest_gate #(
    parameter int LW = 2
) (
    input  logic          busy_i,
    input  logic [LW-1:0] top_i,
    input  logic [LW-1:0] cand_i,
    input  logic          nest_off_i,
    output logic          allow_o
);
    localparam logic [LW-1:0] LAST_LVL = '1;

    logic strictly_higher;
    logic same_last;

    always_comb begin
        strictly_higher = cand_i < top_i;
        same_last       = (cand_i == LAST_LVL) && (top_i == LAST_LVL) && !nest_off_i;
        allow_o         = !busy_i || strictly_higher || same_last;
    end
endmodule

// File: rtl/nic_level_stack.sv
// Holds the levels currently in service.
module nic_level_stack #(
    parameter int DEPTH = 4,
    parameter int LW    = 2,
    parameter int DW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [LW-1:0] lvl_i,
    output logic [DW-1:0] depth_o,
    output logic [LW-1:0] top_o
);
    localparam int            AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [DW-1:0] FULL_D = DW'(DEPTH);

    logic [LW-1:0] ent_q [DEPTH];
    logic [DW-1:0] depth_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            depth_q <= '0;
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else if (pop_i && depth_q != '0) begin
            depth_q <= depth_q - DW'(1);
        end else if (push_i && depth_q != FULL_D) begin
            ent_q[AW'(depth_q)] <= lvl_i;
            depth_q             <= depth_q + DW'(1);
        end
    end

    assign depth_o = depth_q;
    assign top_o   = (depth_q == '0) ? '0 : ent_q[AW'(depth_q - DW'(1))];

    AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> depth_q != FULL_D) else $error("push into full stack"); // R8
    AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && depth_q != '0) |=> depth_q == $past(depth_q) - DW'(1)) else $error("pop miscount"); // R7
    AST_PUSH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i) |=> top_o == $past(lvl_i)) else $error("pushed level lost"); // R4
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
    parameter int NSRC  = 8,
    parameter int NLVL  = 4,
    parameter int DEPTH = 4,
    parameter int SW    = (NSRC > 1) ? $clog2(NSRC) : 1,
    parameter int LW    = $clog2(NLVL),
    parameter int DW    = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req_i,
    input  logic            lvl_we_i,
    input  logic [SW-1:0]   lvl_sel_i,
    input  logic [LW-1:0]   lvl_val_i,
    input  logic            ctl_we_i,
    input  logic            ctl_nest_off_i,
    input  logic            ie_set_i,
    input  logic            ie_clr_i,
    input  logic            eos_i,
    output logic            ack_o,
    output logic [SW-1:0]   ack_idx_o,
    output logic            ie_o,
    output logic [NSRC-1:0] pend_o,
    output logic [DW-1:0]   srv_depth_o,
    output logic [LW-1:0]   srv_lvl_o
);
    import nic_pkg::*;

    localparam logic [LW-1:0] LAST_LVL = '1;
    localparam logic [DW-1:0] LAST_D   = DW'(DEPTH - 1);

    nic_state_e state_q, state_d;

    logic [NSRC-1:0][LW-1:0] lvl_q;
    logic [NSRC-1:0]         pend_q;
    logic                    ie_q;
    logic                    nest_off_q;

    logic          best_any;
    logic [SW-1:0] best_idx;
    logic [LW-1:0] best_lvl;
    logic          allow;
    logic          grant;
    logic          pop;
    logic [DW-1:0] depth;
    logic [LW-1:0] top_lvl;

    nic_arbiter #(.NSRC(NSRC), .LW(LW), .SW(SW)) u_arb (
        .pend_i (pend_q),
        .lvl_i  (lvl_q),
        .any_o  (best_any),
        .idx_o  (best_idx),
        .lvl_o  (best_lvl)
    );

    nic_nest_gate #(.LW(LW)) u_gate (
        .busy_i     (state_q != ST_IDLE),
        .top_i      (top_lvl),
        .cand_i     (best_lvl),
        .nest_off_i (nest_off_q),
        .allow_o    (allow)
    );

    nic_level_stack #(.DEPTH(DEPTH), .LW(LW), .DW(DW)) u_stk (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (grant),
        .pop_i   (pop),
        .lvl_i   (best_lvl),
        .depth_o (depth),
        .top_o   (top_lvl)
    );

    // Decision and next state
    always_comb begin
        grant   = ie_q && !eos_i && best_any && allow && (state_q != ST_FULL);
        pop     = eos_i && (state_q != ST_IDLE);
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (grant) state_d = (DEPTH == 1) ? ST_FULL : ST_ACTIVE;
            ST_ACTIVE: begin
                if (pop && depth == DW'(1))      state_d = ST_IDLE;
                else if (grant && depth == LAST_D) state_d = ST_FULL;
            end
            ST_FULL:   if (pop) state_d = (DEPTH == 1) ? ST_IDLE : ST_ACTIVE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs and programmable state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_o      <= 1'b0;
            ack_idx_o  <= '0;
            ie_q       <= 1'b0;
            pend_q     <= '0;
            nest_off_q <= 1'b0;
            for (int i = 0; i < NSRC; i++) lvl_q[i] <= LAST_LVL;
        end else begin
            ack_o <= grant;
            if (grant) ack_idx_o <= best_idx;
            for (int i = 0; i < NSRC; i++) begin
                pend_q[i] <= (pend_q[i] && !(grant && best_idx == SW'(i))) || req_i[i];
            end
            if (grant)         ie_q <= 1'b0;
            else if (ie_clr_i) ie_q <= 1'b0;
            else if (ie_set_i) ie_q <= 1'b1;
            if (ctl_we_i) nest_off_q <= ctl_nest_off_i;
            if (lvl_we_i) lvl_q[lvl_sel_i] <= lvl_val_i;
        end
    end

    assign ie_o        = ie_q;
    assign pend_o      = pend_q;
    assign srv_depth_o = depth;
    assign srv_lvl_o   = top_lvl;

    AST_ACK_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(ie_q)) else $error("grant without enable"); // R2
    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o) else $error("ack longer than one cycle"); // R4
    AST_ACK_DROPS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> !ie_q) else $error("enable left set after grant"); // R4
    // R5 and R6: a nested grant is strictly more urgent, or a permitted level-3 nest
    AST_NEST_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && $past(depth) != '0) |->
            (top_lvl < $past(top_lvl)) ||
            (top_lvl == LAST_LVL && $past(top_lvl) == LAST_LVL && !$past(nest_off_q)))
        else $error("illegal nesting"); // R6
    AST_IDLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) == (depth == '0)) else $error("state and depth disagree"); // R7
    AST_FULL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL) == (depth == DW'(DEPTH))) else $error("full state mismatch"); // R8
endmodule

// File: tb/nest_irq_ctrl_bench.sv
module nest_irq_ctrl_bench;
    localparam int NSRC = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] t_req = '0;
    logic       t_lwe = 1'b0;
    logic [2:0] t_lsel = '0;
    logic [1:0] t_lval = '0;
    logic       t_cwe = 1'b0;
    logic       t_cval = 1'b0;
    logic       t_set = 1'b0;
    logic       t_clr = 1'b0;
    logic       t_eos = 1'b0;

    logic       ack_o;
    logic [2:0] ack_idx_o;
    logic       ie_o;
    logic [7:0] pend_o;
    logic [2:0] srv_depth_o;
    logic [1:0] srv_lvl_o;

    int checks = 0;
    int fails  = 0;

    // Reference model state
    logic [7:0] m_pend = '0;
    int         m_lvl [NSRC];
    bit         m_ie = 0, m_inh = 0, m_ack = 0;
    int         m_idx = 0;
    int         m_stk [4];
    int         m_dep = 0;

    always #5 clk = ~clk;

    nest_irq_ctrl u_nest_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .req_i(t_req),
        .lvl_we_i(t_lwe), .lvl_sel_i(t_lsel), .lvl_val_i(t_lval),
        .ctl_we_i(t_cwe), .ctl_nest_off_i(t_cval),
        .ie_set_i(t_set), .ie_clr_i(t_clr), .eos_i(t_eos),
        .ack_o(ack_o), .ack_idx_o(ack_idx_o), .ie_o(ie_o), .pend_o(pend_o),
        .srv_depth_o(srv_depth_o), .srv_lvl_o(srv_lvl_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int best_src();
        int b = -1;
        for (int s = 0; s < NSRC; s++)
            if (m_pend[s] && (b < 0 || m_lvl[s] < m_lvl[b])) b = s;
        return b;
    endfunction

    function automatic int exp_top();
        return (m_dep > 0) ? m_stk[m_dep-1] : 0;
    endfunction

    // One clock: predict from the requirements, clock, compare at the negedge
    task automatic cycle();
        int b;
        bit g;
        b = best_src();
        g = 0;
        if (m_ie && !t_eos && b >= 0 && m_dep < 4) begin
            if (m_dep == 0) g = 1;
            else if (m_lvl[b] < m_stk[m_dep-1]) g = 1;
            else if (m_lvl[b] == 3 && m_stk[m_dep-1] == 3 && !m_inh) g = 1;
        end
        m_ack = g;
        if (g) begin
            m_idx = b;
            m_pend[b] = 1'b0;
        end
        m_pend = m_pend | t_req;
        if (g) m_ie = 0;
        else if (t_clr) m_ie = 0;
        else if (t_set) m_ie = 1;
        if (t_eos && m_dep > 0) m_dep--;
        else if (g) begin
            m_stk[m_dep] = m_lvl[b];
            m_dep++;
        end
        if (t_lwe) m_lvl[t_lsel] = int'(t_lval);
        if (t_cwe) m_inh = t_cval;
        @(posedge clk);
        @(negedge clk);
        check(ack_o == m_ack, "R3 ack", int'(ack_o), int'(m_ack));
        if (m_ack) check(int'(ack_idx_o) == m_idx, "R10 ack index", int'(ack_idx_o), m_idx);
        check(ie_o == m_ie, "R9 enable", int'(ie_o), int'(m_ie));
        check(pend_o == m_pend, "R2 pending", int'(pend_o), int'(m_pend));
        check(int'(srv_depth_o) == m_dep, "R7 depth", int'(srv_depth_o), m_dep);
        check(int'(srv_lvl_o) == exp_top(), "R5 top level", int'(srv_lvl_o), exp_top());
        t_req = '0; t_lwe = 0; t_cwe = 0; t_set = 0; t_clr = 0; t_eos = 0;
    endtask

    task automatic set_lvl(input int s, input int v);
        t_lwe = 1; t_lsel = 3'(s); t_lval = 2'(v);
        cycle();
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int s = 0; s < NSRC; s++) m_lvl[s] = 3;
        for (int k = 0; k < 4; k++) m_stk[k] = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(ack_o == 0 && ie_o == 0 && pend_o == 0 && srv_depth_o == 0 && srv_lvl_o == 0,
              "R1 reset", int'({ack_o, ie_o, pend_o, srv_depth_o}), 0);
        rst_n = 1'b1;
        cycle();

        // R6: inhibit on, level-3 request waits during level-3 service
        t_cwe = 1; t_cval = 1; cycle();
        t_req = 8'h04; t_set = 1; cycle();
        cycle();
        check(ack_o && ack_idx_o == 3'd2, "R3 idle grant", int'(ack_idx_o), 2);
        t_req = 8'h20; t_set = 1; cycle();
        cycle(); cycle();
        check(!ack_o && pend_o[5], "R6 held with inhibit", int'(pend_o), 32);
        t_cwe = 1; t_cval = 0; cycle();
        cycle();
        check(ack_o && ack_idx_o == 3'd5 && srv_depth_o == 3'd2, "R6 nest allowed",
              int'(srv_depth_o), 2);
        t_eos = 1; cycle();
        t_eos = 1; cycle();

        // R10: same-level tie goes to lower index
        t_req = 8'h42; cycle();
        t_set = 1; cycle();
        cycle();
        check(ack_o && ack_idx_o == 3'd1, "R10 tie", int'(ack_idx_o), 1);
        t_eos = 1; cycle();
        t_set = 1; cycle();
        cycle();
        check(ack_o && ack_idx_o == 3'd6, "R10 second", int'(ack_idx_o), 6);
        t_eos = 1; cycle();

        // R5: strict preemption for levels 0..2
        set_lvl(3, 1); set_lvl(4, 2); set_lvl(7, 2);
        t_req = 8'h10; t_set = 1; cycle();
        cycle();
        check(ack_o && srv_lvl_o == 2'd2, "R4 push level", int'(srv_lvl_o), 2);
        t_req = 8'h80; t_set = 1; cycle();
        cycle(); cycle();
        check(!ack_o && pend_o[7], "R5 equal level blocked", int'(pend_o), 128);
        t_req = 8'h08; cycle();
        cycle();
        check(ack_o && ack_idx_o == 3'd3 && srv_lvl_o == 2'd1, "R5 preempt", int'(ack_idx_o), 3);
        t_eos = 1; cycle();
        t_eos = 1; cycle();
        t_set = 1; cycle();
        cycle();
        check(ack_o && ack_idx_o == 3'd7, "R5 later grant", int'(ack_idx_o), 7);
        t_eos = 1; cycle();
        set_lvl(3, 3); set_lvl(4, 3); set_lvl(7, 3);

        // R8: four level-3 nests fill the stack, fifth waits
        for (int k = 0; k < 5; k++) begin
            t_req = 8'(1 << k); t_set = 1; cycle();
            cycle();
        end
        check(!ack_o && srv_depth_o == 3'd4 && pend_o[4], "R8 full blocks", int'(srv_depth_o), 4);
        t_eos = 1; cycle();
        check(!ack_o && srv_depth_o == 3'd3, "R7 no grant with eos", int'(srv_depth_o), 3);
        cycle();
        check(ack_o && ack_idx_o == 3'd4, "R8 grant after pop", int'(ack_idx_o), 4);
        for (int k = 0; k < 4; k++) begin
            t_eos = 1; cycle();
        end

        // R7: end of service at depth 0 ignored
        t_eos = 1; cycle();
        check(srv_depth_o == 0 && srv_lvl_o == 0, "R7 empty eos", int'(srv_depth_o), 0);

        // R9: clear beats set
        t_set = 1; t_clr = 1; cycle();
        check(!ie_o, "R9 clear wins", int'(ie_o), 0);
        // R2: pending waits while disabled
        t_req = 8'h01; cycle();
        cycle(); cycle();
        check(!ack_o && pend_o[0], "R2 held while disabled", int'(pend_o), 1);

        // Random phase
        for (int n = 0; n < 600; n++) begin
            t_req = ($urandom_range(0, 3) == 0) ? 8'(1 << $urandom_range(0, 7)) : 8'h00;
            t_set = ($urandom_range(0, 9) < 3);
            t_clr = ($urandom_range(0, 19) == 0);
            t_eos = ($urandom_range(0, 4) == 0);
            if ($urandom_range(0, 9) == 0) begin
                t_lwe = 1; t_lsel = 3'($urandom_range(0, 7)); t_lval = 2'($urandom_range(0, 3));
            end
            if ($urandom_range(0, 19) == 0) begin
                t_cwe = 1; t_cval = 1'($urandom_range(0, 1));
            end
            cycle();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule